// File: doc/BRIEF.md
# PS/2 Host Port Register Front-End

This block gives software a small byte-wide register window onto a PS/2 keyboard or mouse port. On one side sits a simple bus slave: select, write flag, address, access size and byte data, with read data returned one cycle after the access. On the other side sits a byte-stream link to the device. That link offers a receive byte with a valid flag and a pop strobe, and accepts a transmit byte with a valid/ready handshake. The bit-level line serializer is a separate block and is not part of this one.

Software reads the waiting receive byte through the data register, which pops it off the link. A byte written to the data register is handed to the link. The block keeps two raw interrupt conditions. The receive condition is simply "a byte is waiting". The transmit condition drops when a byte is written and rises again once the link has taken it. Two enable bits in the control register mask these conditions. The masked set is visible in an interrupt-status register and drives one level interrupt line. A clock-divisor register is kept only so that software can read back what it wrote.

Top module: `ps2_host_regs`

## Requirements
- R1: After reset the control register reads 0x00, status reads 0x43, clock divisor reads 0x00, interrupt status reads 0x00, and irq and txValid are low.
- R2: Status bit 4 (receive-full) equals rxValid at the time of the read. The other status bits keep the pattern 0x43.
- R3: A read of the data register (offset 0x08) with rxValid high returns rxData and pulses rxPop in that cycle. With rxValid low it returns 0x00 and rxPop stays low.
- R4: Interrupt-status bit 0 equals rxValid ANDed with control bit 4, and it follows rxValid with no register access needed.
- R5: A one-byte write to the data register while no transmit is pending drives txValid high with that byte from the next cycle and clears the raw transmit interrupt. The cycle after the txValid/txReady handshake, txValid is low and the raw transmit interrupt is set again. Interrupt-status bit 1 equals the raw transmit interrupt ANDed with control bit 3.
- R6: While txReady is low, txValid and txData hold and the raw transmit interrupt stays clear. A data-register write made while a byte is pending is dropped.
- R7: irq is high exactly when interrupt-status bits 0 and 1 are not both zero. A control write that changes the enables can raise or lower irq.
- R8: The clock-divisor register (offset 0x0C) reads back the last byte written to it and affects nothing else.
- R9: A write with busSize other than 0 (one byte) changes no register and pulses sizeErr high for one cycle after the access.
- R10: Reads of offsets other than 0x00, 0x04, 0x08, 0x0C and 0x10 return 0x00, and writes to them change nothing.
- R11: The control register (offset 0x00) reads back all 8 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte offset |
| busSize | input | 2 | Access size code, 0 = one byte |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid the cycle after a read |
| sizeErr | output | 1 | One-cycle flag for a write of illegal size |
| rxValid | input | 1 | A received byte is waiting |
| rxData | input | 8 | Waiting received byte |
| rxPop | output | 1 | Consumes the waiting byte |
| txValid | output | 1 | Transmit byte offered |
| txData | output | 8 | Transmit byte |
| txReady | input | 1 | Link accepts the offered byte |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the link keeps rxValid and rxData steady until it sees rxPop, and that it only pops in response to the block. The bench's receive model is a small queue that advances only on rxPop, and its transmit model just toggles txReady at the inactive clock edge. Random traffic keeps txReady high and inserts an idle cycle after each data write, so every expected value can be derived from a simple register model. The stalled-transmit behaviour and the illegal-size writes are exercised only by directed sequences.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_STAT = 'h04;
  localparam int OFF_DATA = 'h08;
  localparam int OFF_DIV  = 'h0C;
  localparam int OFF_ISR  = 'h10;

  localparam int TX_EN_BIT   = 3;
  localparam int RX_EN_BIT   = 4;
  localparam int RXFULL_BIT  = 4;
  localparam int ISR_RX_BIT  = 0;
  localparam int ISR_TX_BIT  = 1;
  localparam logic [7:0] STAT_BASE = 8'h43;

  typedef enum logic [2:0] {
    RS_NONE, RS_CTRL, RS_STAT, RS_DATA, RS_DIV, RS_ISR
  } rdSel_e;

  typedef struct packed {
    logic   wrCtrl;
    logic   wrDiv;
    logic   wrData;
    logic   rdData;
    logic   sizeBad;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/ps2h_decode.sv
module ps2h_decode
  import ps2h_pkg::*;
#(
  parameter int AddrW = 5,
  parameter int SizeW = 2
) (
  input  logic             busSel,
  input  logic             busWrite,
  input  logic [AddrW-1:0] busAddr,
  input  logic [SizeW-1:0] busSize,
  output strobe_t          stb
);
  logic wrOk;
  logic rdOk;

  assign wrOk = busSel && busWrite && (busSize == '0);
  assign rdOk = busSel && !busWrite;

  always_comb begin
    stb         = '0;
    stb.rdSel   = RS_NONE;
    stb.sizeBad = busSel && busWrite && (busSize != '0);
    stb.wrCtrl  = wrOk && (busAddr == AddrW'(OFF_CTRL));
    stb.wrDiv   = wrOk && (busAddr == AddrW'(OFF_DIV));
    stb.wrData  = wrOk && (busAddr == AddrW'(OFF_DATA));
    stb.rdData  = rdOk && (busAddr == AddrW'(OFF_DATA));
    if (rdOk) begin
      case (busAddr)
        AddrW'(OFF_CTRL): stb.rdSel = RS_CTRL;
        AddrW'(OFF_STAT): stb.rdSel = RS_STAT;
        AddrW'(OFF_DATA): stb.rdSel = RS_DATA;
        AddrW'(OFF_DIV):  stb.rdSel = RS_DIV;
        AddrW'(OFF_ISR):  stb.rdSel = RS_ISR;
        default:          stb.rdSel = RS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ps2h_datapath.sv
module ps2h_datapath
  import ps2h_pkg::*;
#(
  parameter int DataW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [DataW-1:0] busWdata,
  output logic [DataW-1:0] busRdata,
  output logic             sizeErr,
  input  logic             rxValid,
  input  logic [DataW-1:0] rxData,
  output logic             rxPop,
  output logic             txValid,
  output logic [DataW-1:0] txData,
  input  logic             txReady,
  output logic             irq,
  output logic [DataW-1:0] ctrlQ,
  output logic             rawTxQ
);
  localparam int IsrW = 2;

  logic [DataW-1:0] divQ;
  logic [DataW-1:0] txBufQ;
  logic             txPendQ;
  logic [IsrW-1:0]  isr;
  logic [DataW-1:0] statVal;
  logic [DataW-1:0] rdNext;

  always_comb begin
    isr             = '0;
    isr[ISR_RX_BIT] = rxValid && ctrlQ[RX_EN_BIT];
    isr[ISR_TX_BIT] = rawTxQ && ctrlQ[TX_EN_BIT];
  end

  always_comb begin
    statVal             = DataW'(STAT_BASE);
    statVal[RXFULL_BIT] = rxValid;
  end

  always_comb begin
    case (stb.rdSel)
      RS_CTRL: rdNext = ctrlQ;
      RS_STAT: rdNext = statVal;
      RS_DATA: rdNext = rxValid ? rxData : '0;
      RS_DIV:  rdNext = divQ;
      RS_ISR:  rdNext = DataW'(isr);
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      divQ     <= '0;
      busRdata <= '0;
      sizeErr  <= 1'b0;
    end else begin
      busRdata <= rdNext;
      sizeErr  <= stb.sizeBad;
      if (stb.wrCtrl) ctrlQ <= busWdata;
      if (stb.wrDiv)  divQ  <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPendQ <= 1'b0;
      txBufQ  <= '0;
      rawTxQ  <= 1'b0;
    end else if (stb.wrData && !txPendQ) begin
      txPendQ <= 1'b1;
      txBufQ  <= busWdata;
      rawTxQ  <= 1'b0;
    end else if (txPendQ && txReady) begin
      txPendQ <= 1'b0;
      rawTxQ  <= 1'b1;
    end
  end

  assign rxPop   = stb.rdData && rxValid;
  assign txValid = txPendQ;
  assign txData  = txBufQ;
  assign irq     = |isr;
endmodule

// File: rtl/ps2_host_regs.sv
module ps2_host_regs
  import ps2h_pkg::*;
#(
  parameter int AddrW = 5,
  parameter int SizeW = 2,
  parameter int DataW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWrite,
  input  logic [AddrW-1:0] busAddr,
  input  logic [SizeW-1:0] busSize,
  input  logic [DataW-1:0] busWdata,
  output logic [DataW-1:0] busRdata,
  output logic             sizeErr,
  input  logic             rxValid,
  input  logic [DataW-1:0] rxData,
  output logic             rxPop,
  output logic             txValid,
  output logic [DataW-1:0] txData,
  input  logic             txReady,
  output logic             irq
);
  strobe_t          stb;
  logic [DataW-1:0] ctrlQ;
  logic             rawTxQ;

  ps2h_decode #(.AddrW(AddrW), .SizeW(SizeW)) u_decode (
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busSize(busSize), .stb(stb)
  );

  ps2h_datapath #(.DataW(DataW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .busRdata(busRdata), .sizeErr(sizeErr), .rxValid(rxValid),
    .rxData(rxData), .rxPop(rxPop), .txValid(txValid), .txData(txData),
    .txReady(txReady), .irq(irq), .ctrlQ(ctrlQ), .rawTxQ(rawTxQ)
  );
endmodule

// File: rtl/ps2h_checker.sv
module ps2h_checker
  import ps2h_pkg::*;
#(
  parameter int AddrW = 5,
  parameter int SizeW = 2,
  parameter int DataW = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             busSel,
  input logic             busWrite,
  input logic [AddrW-1:0] busAddr,
  input logic [SizeW-1:0] busSize,
  input logic             rxValid,
  input logic             rxPop,
  input logic             txValid,
  input logic [DataW-1:0] txData,
  input logic             txReady,
  input logic             sizeErr,
  input logic             irq,
  input logic [DataW-1:0] ctrlQ,
  input logic             rawTxQ
);
  logic dataWr;
  assign dataWr = busSel && busWrite && busSize == '0 && busAddr == AddrW'(OFF_DATA);

  AST_POP_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |-> rxValid); // R3
  AST_TX_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData) && !rawTxQ)); // R6
  AST_TX_DONE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> (!txValid && rawTxQ)); // R5
  AST_TX_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && !txValid) |=> (txValid && !rawTxQ)); // R5
  AST_SIZE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busSize != '0) |=> (sizeErr && $stable(ctrlQ))); // R9
  AST_RX_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && ctrlQ[RX_EN_BIT]) |-> irq); // R4
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!(rxValid && ctrlQ[RX_EN_BIT]) && !(rawTxQ && ctrlQ[TX_EN_BIT])) |-> !irq); // R7
endmodule

bind ps2_host_regs ps2h_checker #(.AddrW(AddrW), .SizeW(SizeW), .DataW(DataW)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busSize(busSize), .rxValid(rxValid), .rxPop(rxPop),
  .txValid(txValid), .txData(txData), .txReady(txReady), .sizeErr(sizeErr),
  .irq(irq), .ctrlQ(ctrlQ), .rawTxQ(rawTxQ)
);

// File: tb/tb_ps2_host_regs.sv
module tb_ps2_host_regs;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWrite = 1'b0;
  logic [4:0] busAddr = '0;
  logic [1:0] busSize = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       sizeErr;
  logic       rxValid;
  logic [7:0] rxData;
  logic       rxPop;
  logic       txValid;
  logic [7:0] txData;
  logic       txReady = 1'b1;
  logic       irq;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  logic [7:0] rxq [16];
  int rxHead = 0;
  int rxTail = 0;
  logic [7:0] txLast = '0;
  int txCount = 0;

  always #5 clk = ~clk;

  assign rxValid = (rxHead != rxTail);
  assign rxData  = rxq[rxHead % 16];

  always @(posedge clk) begin
    if (rxPop) rxHead <= rxHead + 1;
    if (txValid && txReady) begin
      txLast  <= txData;
      txCount <= txCount + 1;
    end
  end

  ps2_host_regs dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .sizeErr(sizeErr), .rxValid(rxValid),
    .rxData(rxData), .rxPop(rxPop), .txValid(txValid), .txData(txData),
    .txReady(txReady), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [4:0] a, input logic [7:0] d, input logic [1:0] sz);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d; busSize = sz;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busSize = '0;
  endtask

  task automatic busRd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic rxPush(input logic [7:0] b);
    rxq[rxTail % 16] = b;
    rxTail++;
  endtask

  function automatic logic [7:0] expIsr(input logic [7:0] c, input logic rawTx, input logic avail);
    return {6'd0, rawTx & c[3], avail & c[4]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual 0x00 expected 0x01");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] mCtrl;
    logic [7:0] mDiv;
    logic       mRawTx;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRd(5'h00, v); check("R1 ctrl", v, 8'h00);
    busRd(5'h04, v); check("R1 status", v, 8'h43);
    busRd(5'h0C, v); check("R1 div", v, 8'h00);
    busRd(5'h10, v); check("R1 isr", v, 8'h00);
    check("R1 irq/txValid", {6'd0, irq, txValid}, 8'h00);

    // R11 control readback
    busWr(5'h00, 8'hE7, 2'd0); busRd(5'h00, v); check("R11 ctrl", v, 8'hE7);
    busWr(5'h00, 8'h00, 2'd0);

    // R8 divisor readback, no side effect
    busWr(5'h0C, 8'hA5, 2'd0); busRd(5'h0C, v); check("R8 div", v, 8'hA5);
    busRd(5'h04, v); check("R8 status untouched", v, 8'h43);
    check("R8 no tx", {7'd0, txValid}, 8'h00);

    // R10 unmapped
    busRd(5'h14, v); check("R10 unmapped read", v, 8'h00);
    busWr(5'h14, 8'hFF, 2'd0); busWr(5'h1C, 8'hFF, 2'd0);
    busRd(5'h00, v); check("R10 ctrl after unmapped write", v, 8'h00);
    busRd(5'h0C, v); check("R10 div after unmapped write", v, 8'hA5);

    // R9 illegal size
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = 5'h00; busWdata = 8'h18; busSize = 2'd2;
    @(negedge clk);
    check("R9 sizeErr pulse", {7'd0, sizeErr}, 8'h01);
    busSel = 1'b0; busWrite = 1'b0; busSize = '0;
    @(negedge clk);
    check("R9 sizeErr one cycle", {7'd0, sizeErr}, 8'h00);
    busRd(5'h00, v); check("R9 ctrl unchanged", v, 8'h00);

    // R3 empty data read
    busRd(5'h08, v); check("R3 empty read", v, 8'h00);
    check("R3 no pop", {7'd0, rxValid}, 8'h00);

    // R2 / R4 / R7 receive path and enables
    @(negedge clk); rxPush(8'h5A);
    busRd(5'h04, v); check("R2 rxFull set", v, 8'h53);
    check("R4 rx irq masked off", {7'd0, irq}, 8'h00);
    busWr(5'h00, 8'h10, 2'd0);
    check("R7 enable raises irq", {7'd0, irq}, 8'h01);
    busRd(5'h10, v); check("R4 isr rx", v, 8'h01);
    busWr(5'h00, 8'h00, 2'd0);
    check("R7 disable lowers irq", {7'd0, irq}, 8'h00);
    busWr(5'h00, 8'h10, 2'd0);
    busRd(5'h08, v); check("R3 popped byte", v, 8'h5A);
    check("R4 irq drops on empty", {7'd0, irq}, 8'h00);
    busRd(5'h04, v); check("R2 rxFull clear", v, 8'h43);

    // R5 transmit with ready link
    busWr(5'h00, 8'h08, 2'd0);
    busWr(5'h08, 8'h11, 2'd0);
    check("R5 txValid", {7'd0, txValid}, 8'h01);
    check("R5 txData", txData, 8'h11);
    @(negedge clk);
    check("R5 tx done", {7'd0, txValid}, 8'h00);
    check("R5 delivered", txLast, 8'h11);
    busRd(5'h10, v); check("R5 isr tx", v, 8'h02);
    check("R7 irq from tx", {7'd0, irq}, 8'h01);

    // R6 stalled link
    txReady = 1'b0;
    busWr(5'h08, 8'h3C, 2'd0);
    check("R6 txValid", {7'd0, txValid}, 8'h01);
    check("R5 raw tx cleared", {7'd0, irq}, 8'h00);
    repeat (3) @(negedge clk);
    busWr(5'h08, 8'h77, 2'd0);
    check("R6 held data", txData, 8'h3C);
    check("R6 still clear", {7'd0, irq}, 8'h00);
    txReady = 1'b1;
    @(negedge clk);
    check("R6 released", {7'd0, txValid}, 8'h00);
    check("R6 irq back", {7'd0, irq}, 8'h01);
    check("R6 dropped write", txLast, 8'h3C);
    @(negedge clk);
    check("R6 count", 8'(txCount), 8'd2);

    // random phase
    mCtrl = 8'h08; mDiv = 8'hA5; mRawTx = 1'b1;
    for (int i = 0; i < 400; i++) begin
      int k;
      logic avail;
      logic [7:0] r;
      k = $urandom % 8;
      r = 8'($urandom);
      avail = (rxHead != rxTail);
      case (k)
        0: begin busWr(5'h00, r, 2'd0); mCtrl = r; end
        1: begin busWr(5'h0C, r, 2'd0); mDiv = r; end
        2: begin
             busWr(5'h08, r, 2'd0); @(negedge clk); mRawTx = 1'b1;
             check("R5 random tx", txLast, r);
           end
        3: begin if (rxTail - rxHead < 15) rxPush(r); @(negedge clk); end
        4: begin busRd(5'h00, v); check("R11 random ctrl", v, mCtrl); end
        5: begin busRd(5'h04, v); check("R2 random status", v, {3'b010, avail, 4'h3}); end
        6: begin
             logic [7:0] e;
             e = avail ? rxq[rxHead % 16] : 8'h00;
             busRd(5'h08, v); check("R3 random data", v, e);
           end
        default: begin
             busRd(5'h10, v); check("R4 random isr", v, expIsr(mCtrl, mRawTx, avail));
           end
      endcase
      avail = (rxHead != rxTail);
      check("R7 random irq", {7'd0, irq}, {7'd0, |expIsr(mCtrl, mRawTx, avail)});
      if (k == 1) begin busRd(5'h0C, v); check("R8 random div", v, mDiv); end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule